// File: doc/BRIEF.md
# SPI Control and Interrupt Front End

This block holds the operating-mode settings of an SPI peripheral and turns buffer fill levels and status flags into interrupt requests. Software reaches it through a small register bus with two addresses: a control register and a status register. The control register exports the module enable, the master/slave choice and the mode-fault detection enable to the rest of the peripheral. The master/slave choice also sets the direction of the serial clock, data and slave-select pins.

The receive and transmit requests compare the buffer counts with programmable trigger numbers, and each request is qualified by a status flag. All of these values arrive as inputs. The error request reports a pending mode fault or overrun. The block keeps the mode-fault and overrun flags itself. It also gives a one-cycle partial-reset pulse whenever the module is switched off, so the neighbouring logic can reinitialize.

Top module: `spi_ctl_front`

## Requirements
- R1: After a synchronous active-low reset, the control and status registers read 0x00, and every output (enable, master, detection enable, partial reset, the three interrupts) is 0.
- R2: The control register at address 0 keeps receive-interrupt enable in bit 7, module enable in bit 6, transmit-interrupt enable in bit 5, error-interrupt enable in bit 4, master select in bit 3 and mode-fault detection enable in bit 2. Bits 1:0 always read 0. Writing 0xFF while the module is disabled and no fault is pending reads back 0xFC.
- R3: While the mode-fault flag is 1, a write that tries to set the module enable from 0 to 1 leaves it at 0. The other fields of that write still take effect.
- R4: While the module enable is 1, writes do not change master select or mode-fault detection enable.
- R5: When the module enable goes from 1 to 0, the partial-reset output is 1 for exactly one cycle. It rises in the same cycle that the enable output first reads 0. A write of 0 to an enable that is already 0 gives no pulse.
- R6: The receive interrupt is 1 only while all three hold: receive-interrupt enable is 1, the receive count is greater than or equal to the receive trigger, and the receive-full input is 1.
- R7: The transmit interrupt is 1 only while all three hold: transmit-interrupt enable is 1, the transmit count is less than or equal to the transmit trigger, and the transmit-empty input is 1.
- R8: The error interrupt is 1 when error-interrupt enable is 1, master select is 0, and either the mode-fault flag or the overrun flag is 1. In master mode it stays 0.
- R9: The master output equals master select (1 = master, which drives the pins; 0 = slave). The effective detection enable is the detection enable bit ANDed with NOT master select. A violation strobe sets no flag while detection is not active.
- R10: The status register at address 1 holds the mode-fault flag in bit 0 and the overrun flag in bit 1. A violation strobe sets bit 0 while detection is active, and an overrun strobe sets bit 1. Writing 0 to a bit clears it, writing 1 leaves it unchanged, and a set wins over a clear in the same cycle.
- R11: Each interrupt rises one clock after its condition becomes true, and it falls in the same cycle that any term of its condition goes false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| rx_count | input | CNT_W | Receive buffer fill count |
| rx_trig | input | CNT_W | Receive trigger number |
| tx_count | input | CNT_W | Transmit buffer fill count |
| tx_trig | input | CNT_W | Transmit trigger number |
| rx_full | input | 1 | Receive-full status flag |
| tx_empty | input | 1 | Transmit-empty status flag |
| mode_viol | input | 1 | Mode-fault violation strobe |
| overrun_evt | input | 1 | Overrun strobe |
| mod_en | output | 1 | Module enable |
| master_dir | output | 1 | Master select and pin direction control |
| modf_det_en | output | 1 | Effective mode-fault detection enable |
| part_rst | output | 1 | One-cycle partial-reset pulse |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench drives the counts exactly at the trigger numbers, one step either side of them, and at the zero and full-scale values. A comparison with the wrong direction or without the equal case would raise or miss an interrupt there. It also tries to enable the module while a fault is pending, and to change the mode while the module runs. A design without those guards would show the enable bit or the master bit changed in the readback. It checks that the partial-reset pulse lasts exactly one cycle and that no pulse appears when a 0 is written to an enable that is already 0. It also checks that an interrupt falls in the same cycle its qualifying flag drops, so a request that was only registered would be caught still high.

// File: rtl/spi_ctl_pkg.sv
// Package: shared field positions, addresses and the control register type
// for the SPI control front end. Assumes an 8-bit register bus.
package spi_ctl_pkg;
    localparam int  REG_W     = 8;
    localparam int  ST_MODF   = 0;
    localparam int  ST_OVR    = 1;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Field order matches control bits 7 down to 2.
    typedef struct packed {
        logic rx_ie;
        logic en;
        logic tx_ie;
        logic err_ie;
        logic master;
        logic mf_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int RSVD_W = REG_W - CTRL_W;
endpackage

// File: rtl/spi_ctl_regs.sv
// Module: control register. Holds the mode bits, refuses enable while a
// mode fault is pending, locks the mode bits while enabled, and pulses
// part_rst for one cycle when the enable drops. Assumes wr_ctrl is already
// decoded for the control address.
module spi_ctl_regs
    import spi_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    input  logic             modf_flag,
    output ctrl_t            ctrl,
    output logic             part_rst
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_d;
    logic  part_rst_q;
    logic [RSVD_W-1:0] unused_rsvd;

    assign unused_rsvd = wdata[RSVD_W-1:0];

    // Next-state of the control fields with the enable and lock guards.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.rx_ie  = wdata[7];
            ctrl_d.tx_ie  = wdata[5];
            ctrl_d.err_ie = wdata[4];
            ctrl_d.en     = wdata[6] ? (ctrl_q.en | ~modf_flag) : 1'b0;
            if (!ctrl_q.en) begin
                ctrl_d.master = wdata[3];
                ctrl_d.mf_en  = wdata[2];
            end
        end
    end

    // Register the control fields and the disable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            part_rst_q <= 1'b0;
        end else begin
            ctrl_q     <= ctrl_d;
            part_rst_q <= ctrl_q.en & ~ctrl_d.en;
        end
    end

    assign ctrl     = ctrl_q;
    assign part_rst = part_rst_q;

    AST_EN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[6] && !ctrl_q.en && modf_flag) |=> !ctrl_q.en); // R3

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.en |=> ($stable(ctrl_q.master) && $stable(ctrl_q.mf_en))); // R4

    AST_PRST_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        part_rst_q |-> (!ctrl_q.en && $past(ctrl_q.en))); // R5

    AST_PRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        part_rst_q |=> !part_rst_q); // R5
endmodule

// File: rtl/spi_ctl_flags.sv
// Module: mode-fault and overrun status flags. Strobes set them and a
// software write of 0 clears them; a set wins over a clear. Assumes
// wr_stat is already decoded for the status address.
module spi_ctl_flags
    import spi_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stat,
    input  logic [1:0] wbits,
    input  logic       det_en,
    input  logic       viol,
    input  logic       ovr_evt,
    output logic       modf,
    output logic       ovr
);
    logic modf_q;
    logic ovr_q;

    // Set on strobe, clear on a written 0, set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modf_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (det_en && viol)
                modf_q <= 1'b1;
            else if (wr_stat && !wbits[ST_MODF])
                modf_q <= 1'b0;
            if (ovr_evt)
                ovr_q <= 1'b1;
            else if (wr_stat && !wbits[ST_OVR])
                ovr_q <= 1'b0;
        end
    end

    assign modf = modf_q;
    assign ovr  = ovr_q;

    AST_MODF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && viol) |=> modf_q); // R10

    AST_MODF_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!modf_q && !(det_en && viol)) |=> !modf_q); // R9

    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr_q); // R10
endmodule

// File: rtl/spi_ctl_irq.sv
// Module: interrupt output stage. Each request rises one cycle after its
// condition and falls in the cycle the condition drops. Assumes the
// condition inputs are free of glitches within a cycle.
module spi_ctl_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic cond_q;

        // Delay the condition by one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) cond_q <= 1'b0;
            else        cond_q <= cond[i];
        end

        assign irq[i] = cond_q & cond[i];

        AST_IRQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> cond[i]); // R11

        AST_IRQ_LATE: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(cond[i])); // R11
    end
endmodule

// File: rtl/spi_ctl_front.sv
// Module: top of the SPI control front end. Decodes the register bus,
// forms the interrupt conditions from counts, triggers and flags, and
// exports the mode controls. Assumes counts and triggers share CNT_W bits.
module spi_ctl_front
    import spi_ctl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_trig,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             mode_viol,
    input  logic             overrun_evt,
    output logic             mod_en,
    output logic             master_dir,
    output logic             modf_det_en,
    output logic             part_rst,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             irq_err
);
    localparam int N_IRQ = 3;

    ctrl_t            ctrl;
    logic             modf;
    logic             ovr;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             det_en;
    logic [N_IRQ-1:0] cond;
    logic [N_IRQ-1:0] irq;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign det_en  = ctrl.mf_en & ~ctrl.master;

    spi_ctl_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wdata     (reg_wdata),
        .modf_flag (modf),
        .ctrl      (ctrl),
        .part_rst  (part_rst)
    );

    spi_ctl_flags i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stat (wr_stat),
        .wbits   (reg_wdata[1:0]),
        .det_en  (det_en),
        .viol    (mode_viol),
        .ovr_evt (overrun_evt),
        .modf    (modf),
        .ovr     (ovr)
    );

    // Interrupt conditions: thresholds qualified by flags and enables.
    always_comb begin
        cond[0] = ctrl.rx_ie && (rx_count >= rx_trig) && rx_full;
        cond[1] = ctrl.tx_ie && (tx_count <= tx_trig) && tx_empty;
        cond[2] = ctrl.err_ie && !ctrl.master && (modf || ovr);
    end

    spi_ctl_irq #(.N(N_IRQ)) i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond),
        .irq   (irq)
    );

    // Read-back multiplexer for the two registers.
    always_comb begin
        if (reg_addr == ADDR_STAT) reg_rdata = {6'b0, ovr, modf};
        else                       reg_rdata = {ctrl, {RSVD_W{1'b0}}};
    end

    assign mod_en      = ctrl.en;
    assign master_dir  = ctrl.master;
    assign modf_det_en = det_en;
    assign irq_rx      = irq[0];
    assign irq_tx      = irq[1];
    assign irq_err     = irq[2];

    AST_ERR_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> !master_dir); // R8

    AST_RX_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_full); // R6

    AST_TX_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> tx_empty); // R7
endmodule

// File: tb/test_spi_ctl_front.sv
// Bench: table walk of interrupt thresholds, then directed corner tests.
module test_spi_ctl_front;
    localparam int CNT_W = 4;
    localparam int NV    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_addr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic [CNT_W-1:0] rx_count = '0, rx_trig = '0, tx_count = '0, tx_trig = '0;
    logic             rx_full = 1'b0, tx_empty = 1'b0, mode_viol = 1'b0, overrun_evt = 1'b0;
    logic             mod_en, master_dir, modf_det_en, part_rst, irq_rx, irq_tx, irq_err;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    // ctrl[27:20] rxc[19:16] rxt[15:12] rxf[11] txc[10:7] txt[6:3] txe[2] exp_rx[1] exp_tx[0]
    localparam logic [27:0] VEC [NV] = '{
        {8'hA0, 4'd4,  4'd4,  1'b1, 4'd2,  4'd2,  1'b1, 1'b1, 1'b1},
        {8'hA0, 4'd3,  4'd4,  1'b1, 4'd3,  4'd2,  1'b1, 1'b0, 1'b0},
        {8'hA0, 4'd15, 4'd0,  1'b0, 4'd0,  4'd15, 1'b0, 1'b0, 1'b0},
        {8'h00, 4'd5,  4'd1,  1'b1, 4'd0,  4'd3,  1'b1, 1'b0, 1'b0},
        {8'h80, 4'd5,  4'd1,  1'b1, 4'd0,  4'd3,  1'b1, 1'b1, 1'b0},
        {8'h20, 4'd5,  4'd1,  1'b1, 4'd0,  4'd3,  1'b1, 1'b0, 1'b1},
        {8'hA0, 4'd0,  4'd0,  1'b1, 4'd15, 4'd15, 1'b1, 1'b1, 1'b1},
        {8'hA0, 4'd7,  4'd8,  1'b1, 4'd9,  4'd8,  1'b1, 1'b0, 1'b0}
    };

    spi_ctl_front #(.CNT_W(CNT_W)) i_spi_ctl_front (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_count(rx_count), .rx_trig(rx_trig), .tx_count(tx_count), .tx_trig(tx_trig),
        .rx_full(rx_full), .tx_empty(tx_empty), .mode_viol(mode_viol),
        .overrun_evt(overrun_evt), .mod_en(mod_en), .master_dir(master_dir),
        .modf_det_en(modf_det_en), .part_rst(part_rst),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic strobe_viol();
        @(negedge clk); mode_viol = 1'b1;
        @(negedge clk); mode_viol = 1'b0;
    endtask

    task automatic strobe_ovr();
        @(negedge clk); overrun_evt = 1'b1;
        @(negedge clk); overrun_evt = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, r); chk("R1 ctrl reset", r, 8'h00);
        rd(1'b1, r); chk("R1 status reset", r, 8'h00);
        chk("R1 outputs reset", {1'b0, mod_en, master_dir, modf_det_en, part_rst, irq_rx, irq_tx, irq_err}, 8'h00);

        // R6 R7 table walk of thresholds and qualifiers
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            rx_count = VEC[v][19:16]; rx_trig = VEC[v][15:12]; rx_full = VEC[v][11];
            tx_count = VEC[v][10:7];  tx_trig = VEC[v][6:3];   tx_empty = VEC[v][2];
            reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = VEC[v][27:20];
            @(negedge clk); reg_wr = 1'b0;
            @(negedge clk);
            chk($sformatf("R6 rx vector %0d", v), {7'b0, irq_rx}, {7'b0, VEC[v][1]});
            chk($sformatf("R7 tx vector %0d", v), {7'b0, irq_tx}, {7'b0, VEC[v][0]});
        end

        // R11 rise one cycle late, fall at once
        wr(1'b0, 8'h80);
        rx_full = 1'b0; rx_count = 4'd2; rx_trig = 4'd2;
        @(negedge clk); rx_full = 1'b1;
        #1 chk("R11 not yet raised", {7'b0, irq_rx}, 8'h00);
        @(negedge clk); chk("R11 raised next cycle", {7'b0, irq_rx}, 8'h01);
        rx_full = 1'b0;
        #1 chk("R11 falls same cycle", {7'b0, irq_rx}, 8'h00);
        rx_full = 1'b1; @(negedge clk); @(negedge clk);
        rx_count = 4'd1;
        #1 chk("R11 falls on count below trigger", {7'b0, irq_rx}, 8'h00);

        // R2 field map and reserved bits
        wr(1'b0, 8'hFF); rd(1'b0, r); chk("R2 readback 0xFF", r, 8'hFC);
        wr(1'b0, 8'h00); wr(1'b0, 8'h03); rd(1'b0, r); chk("R2 reserved read 0", r, 8'h00);

        // R9 master mode disables detection
        wr(1'b0, 8'h0C);
        chk("R9 master dir", {7'b0, master_dir}, 8'h01);
        chk("R9 detection off in master", {7'b0, modf_det_en}, 8'h00);
        strobe_viol(); rd(1'b1, r); chk("R9 no fault in master", r, 8'h00);
        wr(1'b0, 8'h04);
        chk("R9 slave dir", {7'b0, master_dir}, 8'h00);
        chk("R9 detection on in slave", {7'b0, modf_det_en}, 8'h01);

        // R10 fault flag set; R3 enable blocked
        strobe_viol(); rd(1'b1, r); chk("R10 fault flag set", r, 8'h01);
        wr(1'b0, 8'h54); rd(1'b0, r); chk("R3 enable refused", r, 8'h14);
        chk("R3 mod_en low", {7'b0, mod_en}, 8'h00);
        @(negedge clk); chk("R8 err irq on fault", {7'b0, irq_err}, 8'h01);
        wr(1'b1, 8'h01); rd(1'b1, r); chk("R10 write 1 keeps fault", r, 8'h01);
        wr(1'b1, 8'h00); rd(1'b1, r); chk("R10 write 0 clears fault", r, 8'h00);
        wr(1'b0, 8'h54); rd(1'b0, r); chk("R3 enable after clear", r, 8'h54);

        // R4 mode bits locked while enabled
        wr(1'b0, 8'h58); rd(1'b0, r); chk("R4 master locked", r, 8'h54);

        // R5 partial reset pulse
        wr(1'b0, 8'h00);
        chk("R5 pulse and enable low", {6'b0, part_rst, mod_en}, 8'h02);
        @(negedge clk); chk("R5 pulse one cycle", {7'b0, part_rst}, 8'h00);
        wr(1'b0, 8'h00); chk("R5 no pulse when already off", {7'b0, part_rst}, 8'h00);

        // R10 overrun flag; R8 error interrupt slave only
        strobe_ovr(); rd(1'b1, r); chk("R10 overrun set", r, 8'h02);
        wr(1'b0, 8'h10); @(negedge clk);
        chk("R8 err irq on overrun slave", {7'b0, irq_err}, 8'h01);
        wr(1'b0, 8'h18); @(negedge clk);
        chk("R8 err irq off in master", {7'b0, irq_err}, 8'h00);
        wr(1'b1, 8'h00); rd(1'b1, r); chk("R10 overrun cleared", r, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule